// File: doc/BRIEF.md
# Perceptron Write-Update Push Predictor

This block sits beside a directory and decides, on each write to a shared cache line, whether the writer should downgrade and forward its fresh data to recent readers (PUSH) or not (NO-PUSH). It keeps one small perceptron per table entry. Each perceptron has a vector of saturating signed weights, a two-deep history of encoded accesses and the prediction it made at the last write.

On a write, the entry first learns from its previous decision. An external copyset tracker supplies a truth bit that says whether that earlier write was consumed. After training, the entry computes a new decision from the weights and the stored history. Reads only record themselves in the history. Lines that the address filter has not flagged as coherence blocks leave the table untouched.

Top module: `push_pred_top`

## Requirements
- R1: An access is encoded as an N_PROC+2 bit vector: bit i (i < N_PROC) is set only for requester i, bit N_PROC is set for a read, and bit N_PROC+1 is set for a write.
- R2: Each entry keeps the last HIST=2 access vectors. Slot 0 (history bits [N_PROC+1:0]) holds the newest and slot 1 the older. History bit k pairs with weight k. Each tracked access shifts slot 0 into slot 1 and its own vector into slot 0.
- R3: After reset, every weight, history bit and stored prediction is zero, and push_o and push_valid_o are low. The first write to a fresh entry therefore yields NO-PUSH.
- R4: On a tracked write whose stored prediction differs from truth_i, every weight whose history bit is set is incremented when truth_i=1 and decremented when truth_i=0.
- R5: On a tracked write whose stored prediction equals truth_i, no weight changes.
- R6: After training, the decision is PUSH exactly when the sum of the weights whose history bit is set is strictly positive. There is no bias term. The decision becomes the entry's stored prediction.
- R7: A tracked read neither trains nor predicts, raises no push_valid_o, and only shifts its vector into the history.
- R8: An access with coh_blk_i=0 changes no state and raises no push_valid_o.
- R9: Weights are W_BITS=4 bit two's-complement values that saturate at +7 and -8.
- R10: push_valid_o is high for exactly the one cycle after each tracked write strobe, with push_o carrying the decision. push_o is low whenever push_valid_o is low.
- R11: A write's own vector enters the history only after its decision is made, so it does not affect that decision.
- R12: The table has ENTRIES=16 independent direct-mapped entries selected by line_idx_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| acc_valid_i | input | 1 | Access strobe |
| coh_blk_i | input | 1 | Line is flagged as a coherence block |
| line_idx_i | input | IDX_W (4) | Table entry index |
| req_id_i | input | ID_W (2) | Requesting processor |
| is_write_i | input | 1 | 1 = write, 0 = read |
| truth_i | input | 1 | Whether the previous write to this line was consumed |
| push_o | output | 1 | Decision: 1 = PUSH |
| push_valid_o | output | 1 | Decision valid strobe |

## Verification
The first pattern is a producer–consumer sequence: a write, a read by another processor, then a write marked consumed. This shows whether a mispredict trains on exactly the stored history, and whether the write's own vector is kept out of its own decision. A second pattern repeats writes whose truth matches the stored prediction. It separates "no training when correct" from unconditional training. Flagged and unflagged accesses, together with traffic on neighbouring indices, show that reads and unflagged lines leave state alone and that entries stay independent. A long random phase, with truth biased toward one requester, drives weights into both saturation limits. It is compared cycle by cycle against a behavioural model.

// File: rtl/pp_pkg.sv
package pp_pkg;
  typedef enum logic {ACC_RD = 1'b0, ACC_WR = 1'b1} acc_kind_e;
  localparam int unsigned DEF_N_PROC  = 4;
  localparam int unsigned DEF_ENTRIES = 16;
  localparam int unsigned DEF_W_BITS  = 4;
  localparam int unsigned DEF_HIST    = 2;
endpackage

// File: rtl/pp_feat_enc.sv
module pp_feat_enc import pp_pkg::*; #(
  parameter int unsigned N_PROC = DEF_N_PROC,
  parameter int unsigned ID_W   = $clog2(N_PROC),
  parameter int unsigned F      = N_PROC + 2
) (
  input  logic [ID_W-1:0] id_i,
  input  acc_kind_e       kind_i,
  output logic [F-1:0]    vec_o
);
  for (genvar p = 0; p < N_PROC; p++) begin : g_id
    assign vec_o[p] = (id_i == ID_W'(p));
  end
  assign vec_o[N_PROC]   = (kind_i == ACC_RD);
  assign vec_o[N_PROC+1] = (kind_i == ACC_WR);
endmodule

// File: rtl/pp_train.sv
module pp_train import pp_pkg::*; #(
  parameter int unsigned NW     = 12,
  parameter int unsigned W_BITS = DEF_W_BITS
) (
  input  logic [NW*W_BITS-1:0] w_i,
  input  logic [NW-1:0]        hist_i,
  input  logic                 en_i,   // mispredicted
  input  logic                 up_i,   // truth positive
  output logic [NW*W_BITS-1:0] w_o
);
  localparam logic [W_BITS:0] STEP_UP = (W_BITS+1)'(1);
  localparam logic [W_BITS:0] STEP_DN = '1;

  for (genvar k = 0; k < NW; k++) begin : g_w
    logic [W_BITS-1:0] cur;
    logic [W_BITS:0]   ext, sum;
    logic              ovf;
    logic [W_BITS-1:0] clamp;
    assign cur   = w_i[k*W_BITS +: W_BITS];
    assign ext   = {cur[W_BITS-1], cur};
    assign sum   = ext + (up_i ? STEP_UP : STEP_DN);
    assign ovf   = sum[W_BITS] ^ sum[W_BITS-1];
    assign clamp = sum[W_BITS] ? {1'b1, {(W_BITS-1){1'b0}}} : {1'b0, {(W_BITS-1){1'b1}}};
    assign w_o[k*W_BITS +: W_BITS] = (en_i && hist_i[k]) ? (ovf ? clamp : sum[W_BITS-1:0]) : cur;
  end
endmodule

// File: rtl/pp_dot.sv
module pp_dot import pp_pkg::*; #(
  parameter int unsigned NW     = 12,
  parameter int unsigned W_BITS = DEF_W_BITS,
  parameter int unsigned SUM_W  = W_BITS + $clog2(NW) + 1
) (
  input  logic [NW*W_BITS-1:0] w_i,
  input  logic [NW-1:0]        hist_i,
  output logic                 push_o
);
  logic [SUM_W-1:0] acc;
  always_comb begin
    acc = '0;
    for (int k = 0; k < NW; k++) begin
      if (hist_i[k])
        acc = acc + {{(SUM_W-W_BITS){w_i[k*W_BITS+W_BITS-1]}}, w_i[k*W_BITS +: W_BITS]};
    end
  end
  assign push_o = !acc[SUM_W-1] && (acc != '0);
endmodule

// File: rtl/push_pred_top.sv
module push_pred_top import pp_pkg::*; #(
  parameter int unsigned N_PROC  = DEF_N_PROC,
  parameter int unsigned ENTRIES = DEF_ENTRIES,
  parameter int unsigned W_BITS  = DEF_W_BITS,
  parameter int unsigned HIST    = DEF_HIST,
  parameter int unsigned IDX_W   = $clog2(ENTRIES),
  parameter int unsigned ID_W    = $clog2(N_PROC)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             acc_valid_i,
  input  logic             coh_blk_i,
  input  logic [IDX_W-1:0] line_idx_i,
  input  logic [ID_W-1:0]  req_id_i,
  input  logic             is_write_i,
  input  logic             truth_i,
  output logic             push_o,
  output logic             push_valid_o
);
  localparam int unsigned F    = N_PROC + 2;
  localparam int unsigned NW   = HIST * F;
  localparam int unsigned WV_W = NW * W_BITS;

  logic [WV_W-1:0]    w_q [ENTRIES];
  logic [NW-1:0]      h_q [ENTRIES];
  logic [ENTRIES-1:0] p_q;

  logic [WV_W-1:0] sel_w, trained_w;
  logic [NW-1:0]   sel_h, hist_nxt;
  logic            sel_p, decide;
  logic [F-1:0]    vec;
  logic            hit, hit_wr;

  assign hit    = acc_valid_i && coh_blk_i;
  assign hit_wr = hit && is_write_i;
  assign sel_w  = w_q[line_idx_i];
  assign sel_h  = h_q[line_idx_i];
  assign sel_p  = p_q[line_idx_i];

  pp_feat_enc #(.N_PROC(N_PROC), .ID_W(ID_W), .F(F)) u_enc (
    .id_i  (req_id_i),
    .kind_i(acc_kind_e'(is_write_i)),
    .vec_o (vec)
  );

  pp_train #(.NW(NW), .W_BITS(W_BITS)) u_train (
    .w_i   (sel_w),
    .hist_i(sel_h),
    .en_i  (sel_p != truth_i),
    .up_i  (truth_i),
    .w_o   (trained_w)
  );

  // decision uses the pre-shift history
  pp_dot #(.NW(NW), .W_BITS(W_BITS)) u_dot (
    .w_i   (trained_w),
    .hist_i(sel_h),
    .push_o(decide)
  );

  if (HIST > 1) begin : g_shift
    assign hist_nxt = {sel_h[NW-F-1:0], vec};
  end else begin : g_single
    assign hist_nxt = vec;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int e = 0; e < ENTRIES; e++) begin
        w_q[e] <= '0;
        h_q[e] <= '0;
      end
      p_q          <= '0;
      push_o       <= 1'b0;
      push_valid_o <= 1'b0;
    end else begin
      push_valid_o <= hit_wr;
      push_o       <= hit_wr && decide;
      if (hit) begin
        h_q[line_idx_i] <= hist_nxt;
        if (is_write_i) begin
          w_q[line_idx_i] <= trained_w;
          p_q[line_idx_i] <= decide;
        end
      end
    end
  end
endmodule

// File: rtl/push_pred_chk.sv
module push_pred_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic acc_valid_i,
  input logic coh_blk_i,
  input logic is_write_i,
  input logic push_o,
  input logic push_valid_o
);
  a_r10_valid_after_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_valid_i && coh_blk_i && is_write_i) |=> push_valid_o);

  // R7 and R8: reads and unflagged lines never produce a decision
  a_r7_no_valid_otherwise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(acc_valid_i && coh_blk_i && is_write_i) |=> !push_valid_o);

  a_r10_push_qualified: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !push_valid_o |-> !push_o);

  a_r8_unflagged_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_valid_i && !coh_blk_i) |=> (!push_valid_o && !push_o));

  a_r3_reset_quiet: assert property (@(posedge clk_i)
    (!rst_ni && $past(!rst_ni)) |-> (!push_valid_o && !push_o));
endmodule

bind push_pred_top push_pred_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .acc_valid_i (acc_valid_i),
  .coh_blk_i   (coh_blk_i),
  .is_write_i  (is_write_i),
  .push_o      (push_o),
  .push_valid_o(push_valid_o)
);

// File: tb/sim_push_pred_top.sv
module sim_push_pred_top;
  localparam int NP = 4;
  localparam int NE = 16;
  localparam int FW = NP + 2;
  localparam int NWT = 2 * FW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic acc_valid = 1'b0, coh_blk = 1'b0, is_write = 1'b0, truth = 1'b0;
  logic [3:0] line_idx = '0;
  logic [1:0] req_id = '0;
  logic push, push_valid;

  int checks = 0;
  int fails = 0;
  int sat_hi = 0;
  int sat_lo = 0;
  int w_m [NE][NWT];
  bit h_m [NE][NWT];
  bit p_m [NE];
  bit last_push;

  always #4 clk = ~clk;

  push_pred_top u0 (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .acc_valid_i (acc_valid),
    .coh_blk_i   (coh_blk),
    .line_idx_i  (line_idx),
    .req_id_i    (req_id),
    .is_write_i  (is_write),
    .truth_i     (truth),
    .push_o      (push),
    .push_valid_o(push_valid)
  );

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  // one clock of stimulus; model updated and outputs compared after the edge
  task automatic step(bit v, int idx, bit coh, int id, bit wr, bit tr, string tag);
    bit ev, ep;
    bit fv [FW];
    int y;
    ev = 0; ep = 0;
    if (v && coh) begin
      for (int b = 0; b < NP; b++) fv[b] = (id == b);   // R1
      fv[NP]   = !wr;
      fv[NP+1] = wr;
      if (wr) begin
        if (p_m[idx] != tr) begin                      // R4 / R5
          for (int k = 0; k < NWT; k++) begin
            if (h_m[idx][k]) begin
              w_m[idx][k] += tr ? 1 : -1;
              if (w_m[idx][k] > 7) begin w_m[idx][k] = 7; sat_hi++; end   // R9
              if (w_m[idx][k] < -8) begin w_m[idx][k] = -8; sat_lo++; end
            end
          end
        end
        y = 0;
        for (int k = 0; k < NWT; k++) if (h_m[idx][k]) y += w_m[idx][k];
        ep = (y > 0);                                  // R6, before shift (R11)
        p_m[idx] = ep;
        ev = 1;
      end
      for (int k = NWT - 1; k >= FW; k--) h_m[idx][k] = h_m[idx][k-FW];  // R2
      for (int b = 0; b < FW; b++) h_m[idx][b] = fv[b];
    end
    acc_valid = v; line_idx = 4'(idx); coh_blk = coh;
    req_id = 2'(id); is_write = wr; truth = tr;
    @(posedge clk);
    @(negedge clk);
    check({tag, " valid"}, push_valid, ev);
    check({tag, " push"}, push, ep);
    last_push = push;
  endtask

  task automatic idle(string tag);
    step(0, 0, 0, 0, 0, 0, tag);
  endtask

  initial begin
    #(8 * 150000);
    fails++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    for (int e = 0; e < NE; e++) begin
      p_m[e] = 0;
      for (int k = 0; k < NWT; k++) begin w_m[e][k] = 0; h_m[e][k] = 0; end
    end
    repeat (3) @(negedge clk);
    check("R3 reset valid", push_valid, 0);
    check("R3 reset push", push, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R3: fresh entry, truth low -> NO-PUSH
    step(1, 3, 1, 0, 1, 0, "R3 fresh write");
    idle("R10 pulse ends");

    // producer-consumer: R4, R11, R1
    step(1, 5, 1, 0, 1, 0, "R4 w0");
    step(1, 5, 1, 1, 0, 0, "R7 read p1");
    step(1, 5, 1, 0, 1, 1, "R4 w0 truth1");
    check("R11 learned push", last_push, 1);
    idle("R10 idle");

    // R5: matching truth leaves weights alone
    step(1, 9, 1, 2, 1, 0, "R5 w2");
    step(1, 9, 1, 3, 0, 0, "R5 read p3");
    step(1, 9, 1, 2, 1, 0, "R5 match");
    check("R5 no push", last_push, 0);
    step(1, 9, 1, 2, 1, 1, "R5 then mismatch");
    check("R6 push after train", last_push, 1);

    // R8: unflagged accesses ignored, entry stays fresh
    step(1, 7, 0, 1, 1, 1, "R8 unflagged write");
    step(1, 7, 0, 2, 0, 0, "R8 unflagged read");
    step(1, 7, 1, 1, 1, 1, "R8 fresh after ignore");
    check("R8 state untouched", last_push, 0);

    // R12: neighbour entry unaffected by entry 5 training
    step(1, 4, 1, 0, 1, 0, "R12 neighbour");
    check("R12 independent", last_push, 0);
    step(1, 5, 1, 1, 0, 0, "R12 read p1");
    step(1, 5, 1, 0, 1, 1, "R12 own entry");

    // random phase with biased truth: R9, R2, R6
    for (int i = 0; i < 4000; i++) begin
      int id, idx;
      bit wr, tr, coh;
      id  = $urandom_range(0, 3);
      idx = $urandom_range(0, 2);
      wr  = ($urandom_range(0, 2) != 0);
      coh = ($urandom_range(0, 9) != 0);
      tr  = (id == 0) ? 1'b1 : ((id == 3) ? 1'b0 : 1'($urandom_range(0, 1)));
      step(($urandom_range(0, 7) != 0), idx, coh, id, wr, tr, "R2 R6 random");
    end
    check("R9 upper saturation reached", int'(sat_hi > 0), 1);
    check("R9 lower saturation reached", int'(sat_lo > 0), 1);
    idle("R10 final");
    finish_run();
  end
endmodule